// File: doc/BRIEF.md
# ATR-Driven Front-End Switch Controller

This block sets the RF switches and status LEDs of a front end with several transceiver channels. Each channel has a shared transmit/receive port (TX/RX0) and a receive-only port (RX1). Each channel receives a 2-bit auto transmit/receive state: code 0 is idle, 1 is receive only, 2 is transmit only and 3 is full duplex. Bit 1 of the code therefore means transmitting and bit 0 means receiving. Software loads a small table of fast-switch words for every channel. The block then plays the word selected by the live state straight onto the switch pins.

A global mode bit turns on paired indexing. In this mode the states of channel 1 and channel 0 are joined as {ch1, ch0} into a 4-bit index. That index selects one entry from a shared 16-entry table, and the same word drives both channels. Channels 2 and up keep their own tables in every mode. Each channel also has a slow-switch word that only a register write changes. Bit 0 of the active fast word chooses which port the receive path uses, and the LEDs are derived from that bit together with the live state.

The register window is 1 KiB, starts at byte address 0x80000 and is addressed in aligned 32-bit words. The byte offsets are:
- 0x000: mode, bit 0 (1 = paired indexing).
- 0x040 + 4·c: slow word of channel c.
- 0x100 + 0x10·c + 4·s: fast word of channel c for state s.
- 0x200 + 4·i: paired-table entry i.

Top module: `atr_switch_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, every table entry, slow word and the mode bit are cleared. On the next cycle fast_sw, slow_sw, all LED outputs and rd_data read zero.
- R2: With the mode bit at 0, channel c drives fast_sw[c*SW_W +: SW_W] with its table entry at offset 0x100 + 0x10·c + 4·s, where s is its current 2-bit state. The word follows a state change one clock later.
- R3: With the mode bit (offset 0x000, bit 0) at 1, channels 0 and 1 both drive the paired entry at offset 0x200 + 4·{ch1 state, ch0 state}. Channels 2 and 3 keep using their own tables.
- R4: A write that changes the entry currently selected by a channel reaches fast_sw two clocks after the write is presented, and not earlier.
- R5: slow_sw[c*SLOW_W +: SLOW_W] takes the low SLOW_W bits written to offset 0x040 + 4·c one clock after the write. Changes of state, table writes and mode changes leave it unchanged.
- R6: Every mode, slow, table and paired register reads back its stored value, zero-extended, on rd_data one clock after rd_addr presents its address.
- R7: led_trx_red[c] is 1 exactly when bit 1 (transmit) of channel c's state is set.
- R8: With r = bit 0 of channel c's state and p = bit 0 of its active fast word, led_trx_green[c] = r AND NOT transmit AND NOT p, and led_rx1_green[c] = r AND p. Red and green are never both on for the TX/RX0 port.
- R9: The following writes change no register: writes outside the window, writes to an address that is not word aligned, and writes to an unmapped offset inside the window (for example 0x080, or a slow slot at or above NUM_CH). Reads of any of these addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| atr_state | input | 2*NUM_CH | Per-channel 2-bit state, channel c at bits 2c+1:2c |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data, DATA_W = max(SW_W, SLOW_W) |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Read data, one clock after rd_addr |
| fast_sw | output | NUM_CH*SW_W | Registered fast switch words |
| slow_sw | output | NUM_CH*SLOW_W | Slow switch words |
| led_trx_red | output | NUM_CH | TX/RX0 LED red |
| led_trx_green | output | NUM_CH | TX/RX0 LED green |
| led_rx1_green | output | NUM_CH | RX1 LED green |

## Verification
The bench builds the block with four channels, 8-bit fast words, 6-bit slow words, a 20-bit address and paired indexing enabled. At these sizes every state code can be reached on every channel, and all 16 paired indices can be reached together with two independent channels next to them. A slow width narrower than the data width shows that the upper write bits are dropped. Four channels at a 16-slot decode leave unmapped slow slots inside the window, which brings the ignored-address cases within reach.

// File: rtl/atr_sw_pkg.sv
package atr_sw_pkg;
   // register window: 1 KiB, word aligned
   localparam int WIN_LSB = 10;
   localparam int CLS_DEPTH = 4;
   localparam int CMB_DEPTH = 16;
   // region codes, compared against offset bits
   localparam logic [3:0] REGION_SLOW = 4'h1;   // off[9:6]
   localparam logic [1:0] REGION_CLS  = 2'h1;   // off[9:8]
   localparam logic [3:0] REGION_CMB  = 4'h8;   // off[9:6]

   function automatic logic code_tx(input logic [1:0] code);
      return code[1];
   endfunction

   function automatic logic code_rx(input logic [1:0] code);
      return code[0];
   endfunction
endpackage

// File: rtl/atr_addr_dec.sv
module atr_addr_dec
   import atr_sw_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h80000,
   parameter int NUM_CH = 4,
   parameter bit COMBINE_EN = 1'b1
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_mode,
   output logic              hit_slow,
   output logic              hit_cls,
   output logic              hit_cmb,
   output logic [3:0]        slot,
   output logic [3:0]        cls_ch,
   output logic [1:0]        cls_st
);
   logic [WIN_LSB-1:0] off;
   logic               in_win;
   logic               aligned;

   assign off     = addr[WIN_LSB-1:0];
   assign in_win  = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
   assign aligned = (off[1:0] == 2'b00);
   assign slot    = off[5:2];
   assign cls_ch  = off[7:4];
   assign cls_st  = off[3:2];

   assign hit_mode = in_win && aligned && (off[9:2] == 8'd0);
   assign hit_slow = in_win && aligned && (off[9:6] == REGION_SLOW) && (int'(slot) < NUM_CH);
   assign hit_cls  = in_win && aligned && (off[9:8] == REGION_CLS) && (int'(cls_ch) < NUM_CH);
   assign hit_cmb  = COMBINE_EN && in_win && aligned && (off[9:6] == REGION_CMB);
endmodule

// File: rtl/atr_reg_bank.sv
module atr_reg_bank
   import atr_sw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SW_W = 8,
   parameter int SLOW_W = 6,
   parameter int ADDR_W = 20,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h80000,
   parameter bit COMBINE_EN = 1'b1,
   parameter int DATA_W = 8
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   output logic [NUM_CH*CLS_DEPTH*SW_W-1:0] cls_flat,
   output logic [CMB_DEPTH*SW_W-1:0]     cmb_flat,
   output logic [NUM_CH*SLOW_W-1:0]      slow_flat,
   output logic                          comb_mode
);
   localparam int CLS_N = NUM_CH * CLS_DEPTH;

   logic [SW_W-1:0]   cls_q  [CLS_N];
   logic [SW_W-1:0]   cmb_q  [CMB_DEPTH];
   logic [SLOW_W-1:0] slow_q [NUM_CH];
   logic              mode_q;

   logic       w_mode, w_slow, w_cls, w_cmb;
   logic [3:0] w_slot, w_ch;
   logic [1:0] w_st;
   logic       r_mode, r_slow, r_cls, r_cmb;
   logic [3:0] r_slot, r_ch;
   logic [1:0] r_st;
   logic [DATA_W-1:0] rd_next;

   atr_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH),
                  .COMBINE_EN(COMBINE_EN)) u_wdec (
      .addr(wr_addr), .hit_mode(w_mode), .hit_slow(w_slow), .hit_cls(w_cls),
      .hit_cmb(w_cmb), .slot(w_slot), .cls_ch(w_ch), .cls_st(w_st));

   atr_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH),
                  .COMBINE_EN(COMBINE_EN)) u_rdec (
      .addr(rd_addr), .hit_mode(r_mode), .hit_slow(r_slow), .hit_cls(r_cls),
      .hit_cmb(r_cmb), .slot(r_slot), .cls_ch(r_ch), .cls_st(r_st));

   // fast tables and slow words
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CLS_N; i++)     cls_q[i]  <= '0;
         for (int i = 0; i < CMB_DEPTH; i++) cmb_q[i]  <= '0;
         for (int i = 0; i < NUM_CH; i++)    slow_q[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < CLS_N; i++)
            if (w_cls && int'({w_ch, w_st}) == i) cls_q[i] <= wr_data[SW_W-1:0];
         for (int i = 0; i < CMB_DEPTH; i++)
            if (w_cmb && int'(w_slot) == i) cmb_q[i] <= wr_data[SW_W-1:0];
         for (int i = 0; i < NUM_CH; i++)
            if (w_slow && int'(w_slot) == i) slow_q[i] <= wr_data[SLOW_W-1:0];
      end
   end

   // mode bit exists only when paired indexing is built
   if (COMBINE_EN) begin : g_mode
      always_ff @(posedge clk) begin
         if (!rst_n)                mode_q <= 1'b0;
         else if (wr_en && w_mode)  mode_q <= wr_data[0];
      end
   end else begin : g_nomode
      assign mode_q = 1'b0;
   end

   // read path
   always_comb begin
      rd_next = '0;
      if (r_mode) rd_next[0] = mode_q;
      for (int i = 0; i < NUM_CH; i++)
         if (r_slow && int'(r_slot) == i) rd_next[SLOW_W-1:0] = slow_q[i];
      for (int i = 0; i < CLS_N; i++)
         if (r_cls && int'({r_ch, r_st}) == i) rd_next[SW_W-1:0] = cls_q[i];
      for (int i = 0; i < CMB_DEPTH; i++)
         if (r_cmb && int'(r_slot) == i) rd_next[SW_W-1:0] = cmb_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_next;
   end

   for (genvar i = 0; i < CLS_N; i++) begin : g_cls_out
      assign cls_flat[i*SW_W +: SW_W] = cls_q[i];
   end
   for (genvar i = 0; i < CMB_DEPTH; i++) begin : g_cmb_out
      assign cmb_flat[i*SW_W +: SW_W] = cmb_q[i];
   end
   for (genvar i = 0; i < NUM_CH; i++) begin : g_slow_out
      assign slow_flat[i*SLOW_W +: SLOW_W] = slow_q[i];
   end
   assign comb_mode = mode_q;
endmodule

// File: rtl/atr_lookup.sv
module atr_lookup
   import atr_sw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SW_W = 8,
   parameter bit COMBINE_EN = 1'b1
)(
   input  logic [2*NUM_CH-1:0]              atr_state,
   input  logic [NUM_CH*CLS_DEPTH*SW_W-1:0] cls_flat,
   input  logic [CMB_DEPTH*SW_W-1:0]        cmb_flat,
   input  logic                             comb_mode,
   output logic [NUM_CH*SW_W-1:0]           sel_flat
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [1:0]      code;
      logic [SW_W-1:0] own_word;
      assign code     = atr_state[2*c +: 2];
      assign own_word = cls_flat[(c*CLS_DEPTH + int'(code))*SW_W +: SW_W];

      if (COMBINE_EN && c < 2) begin : g_pair
         logic [3:0]      pair_idx;
         logic [SW_W-1:0] pair_word;
         assign pair_idx  = atr_state[3:0];   // {ch1, ch0}
         assign pair_word = cmb_flat[int'(pair_idx)*SW_W +: SW_W];
         assign sel_flat[c*SW_W +: SW_W] = comb_mode ? pair_word : own_word;
      end else begin : g_solo
         assign sel_flat[c*SW_W +: SW_W] = own_word;
      end
   end
endmodule

// File: rtl/atr_led_decode.sv
module atr_led_decode
   import atr_sw_pkg::*;
#(
   parameter int NUM_CH = 4
)(
   input  logic [2*NUM_CH-1:0] atr_state,
   input  logic [NUM_CH-1:0]   rxsel,
   output logic [NUM_CH-1:0]   trx_red,
   output logic [NUM_CH-1:0]   trx_green,
   output logic [NUM_CH-1:0]   rx1_green
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic tx, rx;
      assign tx = code_tx(atr_state[2*c +: 2]);
      assign rx = code_rx(atr_state[2*c +: 2]);
      assign trx_red[c]   = tx;
      assign trx_green[c] = rx & ~tx & ~rxsel[c];
      assign rx1_green[c] = rx & rxsel[c];
   end
endmodule

// File: rtl/atr_switch_ctrl.sv
module atr_switch_ctrl
   import atr_sw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SW_W = 8,
   parameter int SLOW_W = 6,
   parameter int ADDR_W = 20,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h80000,
   parameter bit COMBINE_EN = 1'b1,
   parameter int RXSEL_BIT = 0,
   localparam int DATA_W = (SW_W > SLOW_W) ? SW_W : SLOW_W
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2*NUM_CH-1:0]      atr_state,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic [NUM_CH*SW_W-1:0]   fast_sw,
   output logic [NUM_CH*SLOW_W-1:0] slow_sw,
   output logic [NUM_CH-1:0]        led_trx_red,
   output logic [NUM_CH-1:0]        led_trx_green,
   output logic [NUM_CH-1:0]        led_rx1_green
);
   // elaboration-time parameter checks
   if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH must lie in 2..16");
   end
   if (ADDR_W <= WIN_LSB) begin : g_bad_addr
      $error("ADDR_W must exceed the window size bits");
   end
   if (RXSEL_BIT < 0 || RXSEL_BIT >= SW_W) begin : g_bad_rxsel
      $error("RXSEL_BIT must index into the fast word");
   end
   if (SW_W < 1 || SLOW_W < 1) begin : g_bad_w
      $error("word widths must be positive");
   end

   logic [NUM_CH*CLS_DEPTH*SW_W-1:0] cls_flat;
   logic [CMB_DEPTH*SW_W-1:0]        cmb_flat;
   logic [NUM_CH*SLOW_W-1:0]         slow_flat;
   logic                             comb_mode;
   logic [NUM_CH*SW_W-1:0]           sel_flat;
   logic [NUM_CH-1:0]                rxsel, red_d, grn_d, rx1_d;

   atr_reg_bank #(.NUM_CH(NUM_CH), .SW_W(SW_W), .SLOW_W(SLOW_W), .ADDR_W(ADDR_W),
                  .BASE_ADDR(BASE_ADDR), .COMBINE_EN(COMBINE_EN), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cls_flat(cls_flat), .cmb_flat(cmb_flat),
      .slow_flat(slow_flat), .comb_mode(comb_mode));

   atr_lookup #(.NUM_CH(NUM_CH), .SW_W(SW_W), .COMBINE_EN(COMBINE_EN)) u_lookup (
      .atr_state(atr_state), .cls_flat(cls_flat), .cmb_flat(cmb_flat),
      .comb_mode(comb_mode), .sel_flat(sel_flat));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_rxsel
      assign rxsel[c] = sel_flat[c*SW_W + RXSEL_BIT];
   end

   atr_led_decode #(.NUM_CH(NUM_CH)) u_led (
      .atr_state(atr_state), .rxsel(rxsel),
      .trx_red(red_d), .trx_green(grn_d), .rx1_green(rx1_d));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fast_sw       <= '0;
         led_trx_red   <= '0;
         led_trx_green <= '0;
         led_rx1_green <= '0;
      end else begin
         fast_sw       <= sel_flat;
         led_trx_red   <= red_d;
         led_trx_green <= grn_d;
         led_rx1_green <= rx1_d;
      end
   end

   assign slow_sw = slow_flat;
endmodule

// File: rtl/atr_switch_ctrl_chk.sv
module atr_switch_ctrl_chk
   import atr_sw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SW_W = 8,
   parameter int SLOW_W = 6,
   parameter int ADDR_W = 20,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h80000,
   parameter int DATA_W = 8
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic [2*NUM_CH-1:0]      atr_state,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic [DATA_W-1:0]        rd_data,
   input logic [NUM_CH*SW_W-1:0]   fast_sw,
   input logic [NUM_CH*SLOW_W-1:0] slow_sw,
   input logic [NUM_CH-1:0]        led_trx_red,
   input logic [NUM_CH-1:0]        led_trx_green,
   input logic [NUM_CH-1:0]        led_rx1_green,
   input logic                     comb_mode
);
   logic [NUM_CH-1:0] tx_bits, rx_bits;
   logic              rd_outside;

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         tx_bits[c] = atr_state[2*c+1];
         rx_bits[c] = atr_state[2*c];
      end
   end
   assign rd_outside = (rd_addr[ADDR_W-1:WIN_LSB] != BASE_ADDR[ADDR_W-1:WIN_LSB]);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (fast_sw == '0 && slow_sw == '0 && rd_data == '0 &&
                  led_trx_red == '0 && led_trx_green == '0 && led_rx1_green == '0));

   assert_pair_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(comb_mode)) |-> (fast_sw[SW_W-1:0] == fast_sw[2*SW_W-1:SW_W]));

   assert_slow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(slow_sw));

   assert_red_follows_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (led_trx_red == $past(tx_bits)));

   assert_trx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (led_trx_red & led_trx_green) == '0);

   assert_rx1_needs_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((led_rx1_green & ~$past(rx_bits)) == '0));

   assert_outside_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_outside)) |-> (rd_data == '0));
endmodule

bind atr_switch_ctrl atr_switch_ctrl_chk #(
   .NUM_CH(NUM_CH), .SW_W(SW_W), .SLOW_W(SLOW_W), .ADDR_W(ADDR_W),
   .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .atr_state(atr_state), .wr_en(wr_en),
   .rd_addr(rd_addr), .rd_data(rd_data), .fast_sw(fast_sw), .slow_sw(slow_sw),
   .led_trx_red(led_trx_red), .led_trx_green(led_trx_green),
   .led_rx1_green(led_rx1_green), .comb_mode(comb_mode)
);

// File: tb/atr_switch_ctrl_test.sv
module atr_switch_ctrl_test;
   localparam int NUM_CH = 4;
   localparam int SW_W = 8;
   localparam int SLOW_W = 6;
   localparam int ADDR_W = 20;
   localparam logic [19:0] BASE = 20'h80000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  atr = '0;
   logic        wr_en = 1'b0;
   logic [19:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [19:0] rd_addr = '0;
   logic [7:0]  rd_data;
   logic [31:0] fast_sw;
   logic [23:0] slow_sw;
   logic [3:0]  red, grn, rx1;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] m_cls [16];
   logic [7:0] m_cmb [16];
   logic [5:0] m_slow [4];
   logic       m_mode = 1'b0;

   always #2 clk = ~clk;

   atr_switch_ctrl #(.NUM_CH(NUM_CH), .SW_W(SW_W), .SLOW_W(SLOW_W), .ADDR_W(ADDR_W),
                     .BASE_ADDR(BASE), .COMBINE_EN(1'b1), .RXSEL_BIT(0)) uut (
      .clk(clk), .rst_n(rst_n), .atr_state(atr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fast_sw(fast_sw),
      .slow_sw(slow_sw), .led_trx_red(red), .led_trx_green(grn), .led_rx1_green(rx1));

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_word(int c);
      if (m_mode && c < 2) return m_cmb[atr[3:0]];
      return m_cls[c*4 + int'(atr[2*c +: 2])];
   endfunction

   task automatic check_all(string rq);
      for (int c = 0; c < NUM_CH; c++) begin
         logic [7:0] w;
         logic tx, rx;
         w  = exp_word(c);
         tx = atr[2*c+1];
         rx = atr[2*c];
         chk(rq, $sformatf("fast ch%0d", c), 32'(fast_sw[c*8 +: 8]), 32'(w));
         chk(rq, $sformatf("red ch%0d", c), 32'(red[c]), 32'(tx));
         chk(rq, $sformatf("trx green ch%0d", c), 32'(grn[c]), 32'(rx & ~tx & ~w[0]));
         chk(rq, $sformatf("rx1 green ch%0d", c), 32'(rx1[c]), 32'(rx & w[0]));
         chk(rq, $sformatf("slow ch%0d", c), 32'(slow_sw[c*6 +: 6]), 32'(m_slow[c]));
      end
   endtask

   task automatic wr(logic [19:0] addr, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_map(int off, logic [7:0] d);
      wr(BASE + 20'(off), d);
      if (off == 0)                        m_mode = d[0];
      else if (off >= 'h40 && off < 'h50)  m_slow[(off - 'h40) / 4] = d[5:0];
      else if (off >= 'h100 && off < 'h140) m_cls[(off - 'h100) / 4] = d;
      else if (off >= 'h200 && off < 'h240) m_cmb[(off - 'h200) / 4] = d;
   endtask

   task automatic rd(logic [19:0] addr, output logic [7:0] d);
      @(negedge clk);
      rd_addr = addr;
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic set_atr(logic [7:0] v);
      @(negedge clk);
      atr = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check_all("R1");
      chk("R1", "rd_data", 32'(rd_data), 32'h0);
      rd(BASE, d);           chk("R1", "mode readback", 32'(d), 32'h0);
      rd(BASE + 20'h124, d); chk("R1", "table readback", 32'(d), 32'h0);
   endtask

   task automatic t_classic();
      logic [7:0] pats [7] = '{8'h00, 8'hE4, 8'h1B, 8'hFF, 8'h55, 8'hAA, 8'h39};
      for (int i = 0; i < 16; i++) wr_map('h100 + 4*i, 8'(i*29 + 3));
      @(negedge clk);
      foreach (pats[k]) begin
         set_atr(pats[k]);
         check_all("R2");   // one clock after the state change
      end
   endtask

   task automatic t_update();
      logic [7:0] old;
      set_atr(8'h20);                // ch2 in state 2
      old = m_cls[2*4 + 2];
      wr(BASE + 20'h128, 8'hC6);
      chk("R4", "ch2 one clock after write", 32'(fast_sw[16 +: 8]), 32'(old));
      m_cls[2*4 + 2] = 8'hC6;
      @(negedge clk);
      chk("R4", "ch2 two clocks after write", 32'(fast_sw[16 +: 8]), 32'hC6);
      check_all("R4");
   endtask

   task automatic t_combined();
      for (int i = 0; i < 16; i++) wr_map('h200 + 4*i, 8'(i*37 + 'h11));
      wr_map(0, 8'h01);
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         set_atr({4'(~i), 4'(i)});
         check_all("R3");
      end
      wr_map(0, 8'h00);
      @(negedge clk);
      check_all("R3");
   endtask

   task automatic t_slow();
      logic [7:0] vals [4] = '{8'hFF, 8'h2A, 8'h15, 8'hC3};
      for (int c = 0; c < 4; c++) begin
         wr_map('h40 + 4*c, vals[c]);
         chk("R5", $sformatf("slow ch%0d one clock after write", c),
             32'(slow_sw[c*6 +: 6]), 32'(vals[c][5:0]));
      end
      foreach (vals[k]) begin
         set_atr(vals[k] ^ 8'h5A);
         check_all("R5");
      end
      wr_map('h104, 8'h77);
      wr_map(0, 8'h01);
      @(negedge clk);
      check_all("R5");
      wr_map(0, 8'h00);
      @(negedge clk);
   endtask

   task automatic t_led();
      logic [7:0] pats [5] = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'h1B};
      for (int pass = 0; pass < 2; pass++) begin
         for (int i = 0; i < 16; i++)
            wr_map('h100 + 4*i, {7'(i), 1'((i >> 2) ^ pass)});
         @(negedge clk);
         foreach (pats[k]) begin
            set_atr(pats[k]);
            check_all("R7,R8");
         end
      end
   endtask

   task automatic t_readback();
      logic [7:0] d;
      wr_map(0, 8'h01);
      rd(BASE, d); chk("R6", "mode", 32'(d), 32'(m_mode));
      wr_map(0, 8'h00);
      rd(BASE, d); chk("R6", "mode cleared", 32'(d), 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd(BASE + 20'('h40 + 4*c), d); chk("R6", "slow", 32'(d), 32'(m_slow[c]));
      end
      for (int i = 0; i < 16; i += 3) begin
         rd(BASE + 20'('h100 + 4*i), d); chk("R6", "table", 32'(d), 32'(m_cls[i]));
         rd(BASE + 20'('h200 + 4*i), d); chk("R6", "paired", 32'(d), 32'(m_cmb[i]));
      end
   endtask

   task automatic t_window();
      logic [7:0] d;
      wr(20'h00100, 8'hA5);   // outside, aliases table entry 0
      wr(20'h80500, 8'hA5);   // above the window
      wr(20'h80101, 8'hA5);   // misaligned
      wr(20'h80080, 8'hA5);   // unmapped offset
      wr(20'h80050, 8'h3F);   // slow slot 4, no such channel
      wr(20'h80001, 8'h01);   // misaligned mode
      @(negedge clk);
      check_all("R9");
      rd(BASE + 20'h100, d); chk("R9", "entry 0 kept", 32'(d), 32'(m_cls[0]));
      rd(BASE + 20'h100, d); chk("R9", "entry 0 kept again", 32'(d), 32'(m_cls[0]));
      rd(BASE, d);           chk("R9", "mode kept", 32'(d), 32'h0);
      rd(20'h00100, d);      chk("R9", "outside read", 32'(d), 32'h0);
      rd(20'hC0100, d);      chk("R9", "outside read high", 32'(d), 32'h0);
      rd(20'h80080, d);      chk("R9", "unmapped read", 32'(d), 32'h0);
      rd(20'h80101, d);      chk("R9", "misaligned read", 32'(d), 32'h0);
      rd(20'h80050, d);      chk("R9", "absent slow slot read", 32'(d), 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin m_cls[i] = '0; m_cmb[i] = '0; end
      for (int i = 0; i < 4; i++) m_slow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_classic();
      t_update();
      t_combined();
      t_slow();
      t_led();
      t_readback();
      t_window();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule